// File: doc/BRIEF.md
# Decimal-word multicycle processor core

A small non-pipelined processor whose machine words are four decimal digits, each held as a 4-bit BCD nibble. Each instruction goes through a fixed sequence of five one-clock steps: fetch, decode, execute, memory and write-back. A step sequencer drives the enables on the program counter, the instruction register, the register file, the BCD adder, a result latch and a 100-word memory. The memory step does nothing for register-only operations.

While `rst_ni` is held low, a loader port writes a program image into memory at two-digit BCD addresses. The same port reads any word back at all times. After reset is released the core waits with the PC at 00. A pulse or level on `run_i` starts execution from address 00. The core stops on a halt instruction. It then reports `halted_o` and keeps the PC, the registers and memory frozen until the next reset.

Top module: `dec_core`

## Requirements
- R1: While `rst_ni` is low and `load_we_i` is high, the word on `load_data_i` is written at each clock edge to the BCD address `load_addr_i`. `load_rdata_o` always shows the word stored at `load_addr_i`. `load_we_i` has no effect while `rst_ni` is high.
- R2: During reset and after its release, `pc_o` is 00 and `halted_o` is low. The core does not fetch until `run_i` is sampled high at a clock edge.
- R3: Instruction word layout (digit 3 is the most significant nibble): digit 3 is the opcode, digit 2 is rd (or the source for a store), and digits 1..0 are rs1/rs2, an immediate or a BCD address. Fetch copies mem[PC] into the instruction register and increments the PC in BCD, wrapping 99 to 00. Every instruction takes exactly five clocks. The first fetch happens on the edge after `run_i` is sampled.
- R4: Opcode 1 (ADD) writes rd = rs1 + rs2, using decimal addition with carry between digits.
- R5: Opcode 2 (ADDI) writes rd = rd + the two-digit immediate in digits 1..0.
- R6: Opcode 5 (LOAD) writes rd = mem[addr]. Opcode 7 (STOR) writes mem[addr] = rd. Both use the BCD address in digits 1..0, and no other memory word changes.
- R7: Register x0 always reads 0000, and writes to it are discarded. Registers x1..x9 reset to 0000.
- R8: Opcode 0 (HLT) raises `halted_o` after its write-back step. From then on `pc_o`, the registers and memory stay unchanged until reset, and `pc_o` holds the address that follows the halt word.
- R9: Register writes happen only in the write-back step, from the result latch. Memory writes by the core happen only in the memory step of a store.
- R10: The program 5105, 5206, 1312, 7307, 0000 with 0042 at 05 and 0023 at 06 leaves 0065 at 07 and halts after 26 clocks from the run edge.
- R11: Sums wrap modulo 10000. The carry out of the top digit is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; loader window while low |
| load_we_i | input | 1 | Loader write strobe, honoured only in reset |
| load_addr_i | input | 8 | Loader BCD address (two digits) |
| load_data_i | input | 16 | Loader write word (four BCD digits) |
| load_rdata_o | output | 16 | Word stored at `load_addr_i` |
| run_i | input | 1 | Start execution from the idle state |
| halted_o | output | 1 | Core has executed a halt |
| pc_o | output | 8 | Program counter, two BCD digits |

## Verification
The adder is exercised through ADD with operand pairs that have no carry, a carry rippling through several digits, and a sum of exactly 10000. These three cases separate a binary adder, a missing decimal correction and a kept top carry. ADDI runs once on a normal value and once across the wrap, which shows whether the immediate is zero-extended and added to rd rather than to another register. Programs that write, load and store through x0 show whether the zero register leaks. A program that halts before a store shows whether the halt freezes the sequencer before the store's memory step. PC sampling at chosen clocks of the sample program checks the five-step rhythm.

// File: rtl/dec_pkg.sv
package dec_pkg;
  localparam int DIG_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_DECODE, ST_EXEC, ST_MEM, ST_WB, ST_HALT
  } step_e;

  localparam logic [3:0] OP_HLT  = 4'd0;
  localparam logic [3:0] OP_ADD  = 4'd1;
  localparam logic [3:0] OP_ADDI = 4'd2;
  localparam logic [3:0] OP_LOAD = 4'd5;
  localparam logic [3:0] OP_STOR = 4'd7;

  // two-digit BCD increment, 99 wraps to 00
  function automatic logic [7:0] bcd_inc2(input logic [7:0] v);
    logic [3:0] lo, hi;
    lo = v[3:0];
    hi = v[7:4];
    if (lo >= 4'd9) begin
      lo = 4'd0;
      hi = (hi >= 4'd9) ? 4'd0 : hi + 4'd1;
    end else begin
      lo = lo + 4'd1;
    end
    return {hi, lo};
  endfunction

  function automatic logic [7:0] bcd2_bin(input logic [7:0] v);
    return ({4'd0, v[7:4]} * 8'd10) + {4'd0, v[3:0]};
  endfunction
endpackage

// File: rtl/dec_alu.sv
module dec_alu #(
  parameter int DIGITS = 4,
  localparam int WW = 4 * DIGITS
) (
  input  logic [WW-1:0] a_i,
  input  logic [WW-1:0] b_i,
  output logic [WW-1:0] sum_o
);
  always_comb begin
    logic       carry;
    logic [4:0] raw;
    carry = 1'b0;
    sum_o = '0;
    for (int i = 0; i < DIGITS; i++) begin
      raw = {1'b0, a_i[4*i +: 4]} + {1'b0, b_i[4*i +: 4]} + {4'd0, carry};
      if (raw > 5'd9) begin
        sum_o[4*i +: 4] = raw[3:0] + 4'd6;
        carry = 1'b1;
      end else begin
        sum_o[4*i +: 4] = raw[3:0];
        carry = 1'b0;
      end
    end
    // final carry dropped: modulo 10^DIGITS
  end
endmodule

// File: rtl/dec_regfile.sv
module dec_regfile #(
  parameter int NREG = 10,
  parameter int WW   = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [3:0]    ra_i,
  input  logic [3:0]    rb_i,
  output logic [WW-1:0] rda_o,
  output logic [WW-1:0] rdb_o,
  input  logic          we_i,
  input  logic [3:0]    wa_i,
  input  logic [WW-1:0] wd_i
);
  logic [WW-1:0] regs_q [1:NREG-1];

  for (genvar g = 1; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       regs_q[g] <= '0;
      else if (we_i && wa_i == 4'(g))    regs_q[g] <= wd_i;
    end
  end

  assign rda_o = (ra_i != 4'd0 && 32'(ra_i) < NREG) ? regs_q[ra_i] : '0;
  assign rdb_o = (rb_i != 4'd0 && 32'(rb_i) < NREG) ? regs_q[rb_i] : '0;

  p_wb_lands_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wa_i != 4'd0 && 32'(wa_i) < NREG) |=> regs_q[$past(wa_i)] == $past(wd_i));
endmodule

// File: rtl/dec_mem.sv
module dec_mem #(
  parameter int WORDS = 100,
  parameter int WW    = 16,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [7:0]    waddr_i,
  input  logic [WW-1:0] wdata_i,
  input  logic [7:0]    raddr_i,
  output logic [WW-1:0] rdata_o,
  input  logic [7:0]    daddr_i,
  output logic [WW-1:0] ddata_o
);
  localparam logic [7:0] LIM = 8'(WORDS);

  logic [WW-1:0] mem_q [WORDS];
  logic [7:0] wi, ri, di;

  assign wi = dec_pkg::bcd2_bin(waddr_i);
  assign ri = dec_pkg::bcd2_bin(raddr_i);
  assign di = dec_pkg::bcd2_bin(daddr_i);

  always_ff @(posedge clk_i) begin
    if (we_i && wi < LIM) mem_q[wi[IW-1:0]] <= wdata_i;
  end

  assign rdata_o = (ri < LIM) ? mem_q[ri[IW-1:0]] : '0;
  assign ddata_o = (di < LIM) ? mem_q[di[IW-1:0]] : '0;

  p_store_lands_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wi < LIM) |=> mem_q[$past(wi[IW-1:0])] == $past(wdata_i));
endmodule

// File: rtl/dec_ctrl.sv
module dec_ctrl
  import dec_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [3:0] opcode_i,
  output step_e      step_o,
  output logic       ir_we_o,
  output logic       pc_inc_o,
  output logic       lat_we_o,
  output logic       lat_mem_o,
  output logic       rf_we_o,
  output logic       mem_we_o,
  output logic       halted_o
);
  step_e step_q, step_d;
  logic  is_alu;

  assign is_alu = (opcode_i == OP_ADD) || (opcode_i == OP_ADDI);

  always_comb begin
    step_d = step_q;
    unique case (step_q)
      ST_IDLE:   if (run_i) step_d = ST_FETCH;
      ST_FETCH:  step_d = ST_DECODE;
      ST_DECODE: step_d = ST_EXEC;
      ST_EXEC:   step_d = ST_MEM;
      ST_MEM:    step_d = ST_WB;
      ST_WB:     step_d = (opcode_i == OP_HLT) ? ST_HALT : ST_FETCH;
      ST_HALT:   step_d = ST_HALT;
      default:   step_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_q <= ST_IDLE;
    else         step_q <= step_d;
  end

  assign ir_we_o   = (step_q == ST_FETCH);
  assign pc_inc_o  = (step_q == ST_FETCH);
  assign lat_we_o  = (step_q == ST_EXEC && is_alu) ||
                     (step_q == ST_MEM && opcode_i == OP_LOAD);
  assign lat_mem_o = (step_q == ST_MEM);
  assign rf_we_o   = (step_q == ST_WB) && (is_alu || opcode_i == OP_LOAD);
  assign mem_we_o  = (step_q == ST_MEM) && (opcode_i == OP_STOR);
  assign halted_o  = (step_q == ST_HALT);
  assign step_o    = step_q;

  p_wb_next_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q == ST_WB && opcode_i != OP_HLT) |=> step_q == ST_FETCH);
  p_fetch_after_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q == ST_IDLE && !run_i) |=> step_q == ST_IDLE);
  p_halt_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q == ST_HALT) |=> step_q == ST_HALT);
endmodule

// File: rtl/dec_core.sv
module dec_core
  import dec_pkg::*;
#(
  parameter int DIGITS    = 4,
  parameter int NREG      = 10,
  parameter int MEM_WORDS = 100,
  localparam int WW       = 4 * DIGITS,
  localparam int AW       = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_we_i,
  input  logic [AW-1:0] load_addr_i,
  input  logic [WW-1:0] load_data_i,
  output logic [WW-1:0] load_rdata_o,
  input  logic          run_i,
  output logic          halted_o,
  output logic [AW-1:0] pc_o
);
  step_e         step;
  logic          ir_we, pc_inc, lat_we, lat_mem, rf_we, core_mem_we;
  logic [AW-1:0] pc_q;
  logic [WW-1:0] ir_q, lat_q;
  logic [3:0]    op, f_rd, f_hi, f_lo;
  logic [3:0]    ra;
  logic [WW-1:0] rda, rdb, alu_b, alu_sum, mem_rdata;
  logic          mem_we;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [WW-1:0] mem_wdata;

  assign op   = ir_q[WW-1 -: 4];
  assign f_rd = ir_q[WW-5 -: 4];
  assign f_hi = ir_q[7:4];
  assign f_lo = ir_q[3:0];

  dec_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_i),
    .opcode_i (op),
    .step_o   (step),
    .ir_we_o  (ir_we),
    .pc_inc_o (pc_inc),
    .lat_we_o (lat_we),
    .lat_mem_o(lat_mem),
    .rf_we_o  (rf_we),
    .mem_we_o (core_mem_we),
    .halted_o (halted_o)
  );

  // ADD reads rs1 on port a; ADDI and STOR read rd there
  assign ra = (op == OP_ADD) ? f_hi : f_rd;

  dec_regfile #(.NREG(NREG), .WW(WW)) u_rf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ra_i  (ra),
    .rb_i  (f_lo),
    .rda_o (rda),
    .rdb_o (rdb),
    .we_i  (rf_we),
    .wa_i  (f_rd),
    .wd_i  (lat_q)
  );

  assign alu_b = (op == OP_ADDI) ? {{(WW-8){1'b0}}, ir_q[7:0]} : rdb;

  dec_alu #(.DIGITS(DIGITS)) u_alu (
    .a_i  (rda),
    .b_i  (alu_b),
    .sum_o(alu_sum)
  );

  // loader owns the write port during reset, core afterwards
  assign mem_we    = rst_ni ? core_mem_we : load_we_i;
  assign mem_waddr = rst_ni ? ir_q[7:0]   : load_addr_i;
  assign mem_wdata = rst_ni ? rda         : load_data_i;
  assign mem_raddr = (step == ST_FETCH) ? pc_q : ir_q[7:0];

  dec_mem #(.WORDS(MEM_WORDS), .WW(WW)) u_mem (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (mem_we),
    .waddr_i(mem_waddr),
    .wdata_i(mem_wdata),
    .raddr_i(mem_raddr),
    .rdata_o(mem_rdata),
    .daddr_i(load_addr_i),
    .ddata_o(load_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      ir_q  <= '0;
      lat_q <= '0;
    end else begin
      if (pc_inc) pc_q <= bcd_inc2(pc_q);
      if (ir_we)  ir_q <= mem_rdata;
      if (lat_we) lat_q <= lat_mem ? mem_rdata : alu_sum;
    end
  end

  assign pc_o = pc_q;

  p_pc_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_we |=> pc_q == bcd_inc2($past(pc_q)));
  p_ir_only_fetch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ir_we |=> $stable(ir_q));
  p_pc_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> ($stable(pc_q) && halted_o));
  p_no_mem_write_halted_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !mem_we);
  p_rf_write_wb_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we |-> step == ST_WB);
endmodule

// File: tb/dec_core_tb.sv
module dec_core_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_we = 1'b0;
  logic [7:0]  load_addr = '0;
  logic [15:0] load_data = '0;
  logic [15:0] load_rdata;
  logic        run = 1'b0;
  logic        halted;
  logic [7:0]  pc;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dec_core u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .load_we_i   (load_we),
    .load_addr_i (load_addr),
    .load_data_i (load_data),
    .load_rdata_o(load_rdata),
    .run_i       (run),
    .halted_o    (halted),
    .pc_o        (pc)
  );

  function automatic int to_int(input logic [15:0] b);
    return b[15:12]*1000 + b[11:8]*100 + b[7:4]*10 + b[3:0];
  endfunction

  function automatic logic [15:0] to_bcd(input int v);
    logic [15:0] r;
    r[3:0]   = 4'(v % 10);
    r[7:4]   = 4'((v / 10) % 10);
    r[11:8]  = 4'((v / 100) % 10);
    r[15:12] = 4'((v / 1000) % 10);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic enter_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    run = 1'b0;
  endtask

  task automatic poke(input logic [7:0] a, input logic [15:0] d);
    load_addr = a;
    load_data = d;
    load_we = 1'b1;
    @(negedge clk);
    load_we = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [15:0] d);
    load_addr = a;
    #1;
    d = load_rdata;
  endtask

  task automatic leave_reset();
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic run_to_halt(output int n);
    n = 0;
    @(negedge clk);
    run = 1'b1;
    while (!halted && n < 1000) begin
      @(posedge clk);
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk(pc == 8'h00, "R2 pc in reset", {8'h0, pc}, 16'h0000);
    chk(!halted, "R2 halted in reset", {15'h0, halted}, 16'h0000);
    enter_reset();
    poke(8'h33, 16'h4821);
    poke(8'h00, 16'h0000);
    peek(8'h33, d);
    chk(d == 16'h4821, "R1 loader readback", d, 16'h4821);
    leave_reset();
    repeat (10) @(negedge clk);
    chk(pc == 8'h00, "R2 idle without run", {8'h0, pc}, 16'h0000);
    chk(!halted, "R2 idle not halted", {15'h0, halted}, 16'h0000);
  endtask

  task automatic t_sample();
    logic [15:0] d;
    int n;
    enter_reset();
    poke(8'h00, 16'h5105);
    poke(8'h01, 16'h5206);
    poke(8'h02, 16'h1312);
    poke(8'h03, 16'h7307);
    poke(8'h04, 16'h0000);
    poke(8'h05, 16'h0042);
    poke(8'h06, 16'h0023);
    poke(8'h07, 16'h0000);
    leave_reset();
    @(negedge clk);
    run = 1'b1;
    n = 0;
    while (!halted && n < 1000) begin
      @(posedge clk);
      @(negedge clk);
      n++;
      if (n == 1) chk(pc == 8'h00, "R3 pc before first fetch", {8'h0, pc}, 16'h0000);
      if (n == 2) chk(pc == 8'h01, "R3 pc after first fetch", {8'h0, pc}, 16'h0001);
      if (n == 6) chk(pc == 8'h01, "R3 pc through five steps", {8'h0, pc}, 16'h0001);
      if (n == 7) chk(pc == 8'h02, "R3 pc second fetch", {8'h0, pc}, 16'h0002);
    end
    chk(n == 26, "R10 R3 cycles to halt", 16'(n), 16'd26);
    peek(8'h07, d);
    chk(d == 16'h0065, "R10 sum stored", d, 16'h0065);
    peek(8'h05, d);
    chk(d == 16'h0042, "R6 source word intact", d, 16'h0042);
    chk(pc == 8'h05, "R8 pc after halt", {8'h0, pc}, 16'h0005);
  endtask

  // R4 R11: ADD through LOAD/STOR
  task automatic t_add(input int a, input int b);
    logic [15:0] d, e;
    int n;
    enter_reset();
    poke(8'h00, 16'h5110);
    poke(8'h01, 16'h5211);
    poke(8'h02, 16'h1312);
    poke(8'h03, 16'h7312);
    poke(8'h04, 16'h0000);
    poke(8'h10, to_bcd(a));
    poke(8'h11, to_bcd(b));
    poke(8'h12, 16'h1111);
    leave_reset();
    run_to_halt(n);
    e = to_bcd((a + b) % 10000);
    peek(8'h12, d);
    chk(d == e, "R4 R11 decimal add", d, e);
  endtask

  task automatic t_addi(input int a, input int imm);
    logic [15:0] d, e;
    int n;
    enter_reset();
    poke(8'h00, 16'h5410);
    poke(8'h01, {8'h24, to_bcd(imm)[7:0]});
    poke(8'h02, 16'h7411);
    poke(8'h03, 16'h0000);
    poke(8'h10, to_bcd(a));
    poke(8'h11, 16'h2222);
    leave_reset();
    run_to_halt(n);
    e = to_bcd((a + imm) % 10000);
    peek(8'h11, d);
    chk(d == e, "R5 R11 add immediate", d, e);
    chk(n == 21, "R3 four-instruction cycles", 16'(n), 16'd21);
  endtask

  task automatic t_x0();
    logic [15:0] d;
    int n;
    enter_reset();
    poke(8'h00, 16'h2033);
    poke(8'h01, 16'h7010);
    poke(8'h02, 16'h5011);
    poke(8'h03, 16'h7012);
    poke(8'h04, 16'h0000);
    poke(8'h10, 16'h1234);
    poke(8'h11, 16'h5555);
    poke(8'h12, 16'h7777);
    leave_reset();
    run_to_halt(n);
    peek(8'h10, d);
    chk(d == 16'h0000, "R7 x0 after addi", d, 16'h0000);
    peek(8'h12, d);
    chk(d == 16'h0000, "R7 x0 after load", d, 16'h0000);
    peek(8'h11, d);
    chk(d == 16'h5555, "R6 load leaves memory", d, 16'h5555);
  endtask

  task automatic t_halt_freeze();
    logic [15:0] d;
    int n;
    enter_reset();
    poke(8'h00, 16'h0000);
    poke(8'h01, 16'h7130);
    poke(8'h30, 16'h0777);
    poke(8'h20, 16'h0000);
    leave_reset();
    run_to_halt(n);
    chk(n == 6, "R8 halt cycles", 16'(n), 16'd6);
    repeat (20) @(negedge clk);
    chk(halted, "R8 halted sticky", {15'h0, halted}, 16'h0001);
    chk(pc == 8'h01, "R8 pc frozen", {8'h0, pc}, 16'h0001);
    peek(8'h30, d);
    chk(d == 16'h0777, "R8 store after halt skipped", d, 16'h0777);
    load_addr = 8'h20;
    load_data = 16'h1111;
    load_we = 1'b1;
    @(negedge clk);
    load_we = 1'b0;
    peek(8'h20, d);
    chk(d == 16'h0000, "R1 loader ignored out of reset", d, 16'h0000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    t_sample();
    t_add(1234, 4321);
    t_add(958, 47);
    t_add(9999, 1);
    t_add(4567, 5433);
    t_addi(48, 57);
    t_addi(9990, 15);
    t_x0();
    t_halt_freeze();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule